// File: doc/BRIEF.md
# Programmable-Rate ADC Conversion Sequencer

This block runs a successive-approximation converter that has a conversion-start input, a busy output and a parallel result bus. A divider paces the conversion-start pulses, and a two-bit select picks one of four sample rates that step by factors of four. At the default divider base with a 200 MHz clock, the four rates are 800 kHz, 200 kHz, 50 kHz and 12.5 kHz. The divider takes a new select value only when a period ends, so the sample spacing never takes an odd length in between.

The block watches the busy flag through a synchroniser. When busy falls, it raises a read strobe for a fixed number of cycles and latches the result bus on the last cycle of the strobe. The captured word goes out with a one-cycle valid strobe. The result stream is valid-only and the converter cannot be stalled, so there is no ready input. The consumer must take each word in the cycle its valid is high. The word stays on the output until the next capture replaces it.

If a conversion is still running when the next start falls due, the block skips that start and sets a sticky overrun flag. Only reset clears the flag.

Top module: `adc_conv_seq`

## Requirements
- R1: The spacing between rising edges of `conv_start` is BASE_DIV × 4^`rate_sel` clock cycles. Encoding 0 is the fastest rate (×1), then 1 is ×4, 2 is ×16 and 3 is ×64.
- R2: Each `conv_start` pulse is high for exactly CNV_W cycles.
- R3: The first `conv_start` pulse appears in the first clock cycle after reset is released.
- R4: A change of `rate_sel` takes effect at the next period boundary. The period already running completes at its old length.
- R5: `rd_strobe` rises SYNC_STAGES+1 cycles after `adc_busy` falls and stays high for exactly RD_W cycles.
- R6: `smp_data` takes the value `adc_data` had in the last `rd_strobe` cycle. `smp_valid` rises in the cycle `rd_strobe` falls and is high for exactly one cycle.
- R7: `smp_data` changes only together with `smp_valid` and holds its value between captures.
- R8: When a start falls due while the previous conversion's busy has not yet been seen to end, that start is skipped, so the spacing doubles. `overrun` then goes high and stays high until reset. `overrun` stays low while conversions keep pace.
- R9: While reset is asserted, `conv_start`, `rd_strobe`, `smp_valid`, `overrun` and `smp_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_sel | input | 2 | Sample-rate select, 0 fastest to 3 slowest |
| adc_busy | input | 1 | Converter busy flag, asynchronous |
| adc_data | input | DATA_W | Converter parallel result bus |
| conv_start | output | 1 | Conversion-start pulse to the converter |
| rd_strobe | output | 1 | Read strobe to the converter's output port |
| smp_data | output | DATA_W | Last captured sample |
| smp_valid | output | 1 | One-cycle strobe marking a new sample |
| overrun | output | 1 | Sticky flag: a start was skipped |

## Verification
The bench walks every rate encoding and checks the spacing between starts. A divider that mis-scales or mis-decodes the select would give a wrong spacing. It also changes the select just after a start; a divider that reloads the select at once would cut the running period short. A converter model supplies fresh result words and long conversions. An edge detector with the wrong number of stages would move the strobe off its expected cycle. A design that latched at the start of the strobe would still pass the value check, because the model holds its data steady. A design that let a late conversion through would not double the spacing and would leave `overrun` low. Reset is applied in mid-operation. After it, the first start must come at once, and a flag that did not stick would show up low after later normal periods.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef logic [1:0] rate_sel_t;

  localparam int NUM_RATES = 4;

  // Rate select encoding: each step slows the conversion rate by four.
  function automatic int rate_mult(input int sel);
    return 1 << (2 * sel);
  endfunction

endpackage

// File: rtl/adc_rate_pacer.sv
module adc_rate_pacer
  import adc_seq_pkg::*;
#(
  parameter int BASE_DIV = 250
) (
  input  logic      clk,
  input  logic      rst_n,
  input  rate_sel_t rate_sel,
  output logic      tick
);

  localparam int MAX_PERIOD = BASE_DIV * rate_mult(NUM_RATES - 1);
  localparam int CNT_W      = $clog2(MAX_PERIOD);

  logic [CNT_W-1:0] reload_tab [NUM_RATES];
  logic [CNT_W-1:0] cnt;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_reload
    assign reload_tab[g] = CNT_W'(BASE_DIV * rate_mult(g) - 1);
  end

  // The select is sampled only when the count expires.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt == '0) begin
      cnt <= reload_tab[rate_sel];
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign tick = (cnt == '0);

endmodule

// File: rtl/adc_start_gen.sv
module adc_start_gen #(
  parameter int CNV_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic conv_done,
  output logic conv_start,
  output logic overrun
);

  localparam int WCNT_W = $clog2(CNV_W + 1);

  logic              in_flight;
  logic [WCNT_W-1:0] wcnt;
  logic              issue;
  logic              skip;

  // A conversion whose end is detected in the same cycle counts as finished.
  assign issue = tick && (!in_flight || conv_done);
  assign skip  = tick && in_flight && !conv_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_flight <= 1'b0;
    end else if (issue) begin
      in_flight <= 1'b1;
    end else if (conv_done) begin
      in_flight <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_start <= 1'b0;
      wcnt       <= '0;
    end else if (issue) begin
      conv_start <= 1'b1;
      wcnt       <= WCNT_W'(CNV_W - 1);
    end else if (wcnt != '0) begin
      wcnt <= wcnt - 1'b1;
    end else begin
      conv_start <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun <= 1'b0;
    end else if (skip) begin
      overrun <= 1'b1;
    end
  end

endmodule

// File: rtl/adc_busy_edge.sv
module adc_busy_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_async,
  output logic busy_fall
);

  logic [SYNC_STAGES:0] pipe;

  for (genvar s = 0; s <= SYNC_STAGES; s++) begin : g_pipe
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= 1'b0;
        else        pipe[0] <= busy_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= 1'b0;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  // The last stage is the previous value of the synchronised busy flag.
  assign busy_fall = pipe[SYNC_STAGES] && !pipe[SYNC_STAGES-1];

endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl #(
  parameter int DATA_W = 18,
  parameter int RD_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_fall,
  input  logic [DATA_W-1:0] adc_data,
  output logic              rd_strobe,
  output logic [DATA_W-1:0] smp_data,
  output logic              smp_valid
);

  localparam int RCNT_W = $clog2(RD_W + 1);

  logic [RCNT_W-1:0] rcnt;
  logic              last_cycle;

  assign last_cycle = (rcnt == RCNT_W'(1));
  assign rd_strobe  = (rcnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt <= '0;
    end else if (busy_fall && !rd_strobe) begin
      rcnt <= RCNT_W'(RD_W);
    end else if (rd_strobe) begin
      rcnt <= rcnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_data  <= '0;
      smp_valid <= 1'b0;
    end else begin
      smp_valid <= last_cycle;
      if (last_cycle) smp_data <= adc_data;
    end
  end

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int DATA_W      = 18,
  parameter int BASE_DIV    = 250,
  parameter int CNV_W       = 3,
  parameter int RD_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rate_sel,
  input  logic              adc_busy,
  input  logic [DATA_W-1:0] adc_data,
  output logic              conv_start,
  output logic              rd_strobe,
  output logic [DATA_W-1:0] smp_data,
  output logic              smp_valid,
  output logic              overrun
);

  logic tick;
  logic busy_fall;

  adc_rate_pacer #(.BASE_DIV(BASE_DIV)) u_pacer (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .tick     (tick)
  );

  adc_busy_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_async (adc_busy),
    .busy_fall  (busy_fall)
  );

  adc_start_gen #(.CNV_W(CNV_W)) u_start (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .conv_done  (busy_fall),
    .conv_start (conv_start),
    .overrun    (overrun)
  );

  adc_read_ctrl #(.DATA_W(DATA_W), .RD_W(RD_W)) u_read (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_fall (busy_fall),
    .adc_data  (adc_data),
    .rd_strobe (rd_strobe),
    .smp_data  (smp_data),
    .smp_valid (smp_valid)
  );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int DATA_W = 18,
  parameter int CNV_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_start,
  input logic              rd_strobe,
  input logic [DATA_W-1:0] smp_data,
  input logic              smp_valid,
  input logic              overrun
);

  logic [15:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hi_len <= '0;
    else if (conv_start) hi_len <= hi_len + 1'b1;
    else                 hi_len <= '0;
  end

  AST_START_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    hi_len <= 16'(CNV_W)); // R2

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid); // R6

  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_valid) |-> ($past(rd_strobe) && !rd_strobe)); // R6

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(smp_data) |-> smp_valid); // R7

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R8

endmodule

bind adc_conv_seq adc_seq_chk #(.DATA_W(DATA_W), .CNV_W(CNV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_start (conv_start),
  .rd_strobe  (rd_strobe),
  .smp_data   (smp_data),
  .smp_valid  (smp_valid),
  .overrun    (overrun)
);

// File: tb/sim_adc_conv_seq.sv
`timescale 1ns/1ps
module sim_adc_conv_seq;

  localparam int DATA_W = 18;
  localparam int BASE   = 40;
  localparam int CNV_W  = 3;
  localparam int RD_W   = 4;
  localparam int NVEC   = 6;
  // Each vector: rate select in bits 15:14, conversion length in cycles in bits 13:0.
  localparam logic [15:0] VEC [NVEC] = '{
    {2'd0, 14'd10}, {2'd1, 14'd20}, {2'd2, 14'd15},
    {2'd3, 14'd30}, {2'd1, 14'd5},  {2'd0, 14'd25}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        rate_sel = 2'd0;
  logic              adc_busy = 1'b0;
  logic [DATA_W-1:0] adc_data = '0;
  logic              conv_start, rd_strobe, smp_valid, overrun;
  logic [DATA_W-1:0] smp_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Converter model and monitor state.
  int conv_len = 10;
  int left = 0;
  int cyc = 0;
  int last_rise = -1;
  int last_interval = 0;
  int n_rises = 0;
  int n_valid = 0;
  int fall_cyc = -1000;
  int cs_hi = 0;
  int rd_hi = 0;
  logic [DATA_W-1:0] model_val = '0;
  logic [DATA_W-1:0] prev_data = '0;
  logic cs_prev = 0, rd_prev = 0, v_prev = 0;
  bit stray = 0;

  always #2.5 clk = ~clk;

  adc_conv_seq #(.DATA_W(DATA_W), .BASE_DIV(BASE), .CNV_W(CNV_W), .RD_W(RD_W)) u0 (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .adc_busy(adc_busy),
    .adc_data(adc_data), .conv_start(conv_start), .rd_strobe(rd_strobe),
    .smp_data(smp_data), .smp_valid(smp_valid), .overrun(overrun)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, actual, expected, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      adc_busy = 0; left = 0; last_rise = -1; cs_prev = 0; rd_prev = 0;
      v_prev = 0; cs_hi = 0; rd_hi = 0; stray = 0; prev_data = '0;
    end else begin
      // Converter model: ignores starts while busy.
      if (!adc_busy && conv_start && !cs_prev) begin
        adc_busy = 1; left = conv_len;
      end else if (adc_busy) begin
        left--;
        if (left == 0) begin
          model_val = DATA_W'(model_val * 7 + 18'h1357 + cyc);
          adc_data = model_val;
          adc_busy = 0;
          fall_cyc = cyc;
        end
      end
      // Start pulses: spacing and width.
      if (conv_start && !cs_prev) begin
        if (last_rise >= 0) last_interval = cyc - last_rise;
        last_rise = cyc; n_rises++;
      end
      if (conv_start) cs_hi++;
      if (!conv_start && cs_prev) begin check("R2 start width", cs_hi, CNV_W); cs_hi = 0; end
      // Read strobe: latency from busy fall and width.
      if (rd_strobe && !rd_prev) check("R5 strobe latency", cyc - fall_cyc, 3);
      if (rd_strobe) rd_hi++;
      if (!rd_strobe && rd_prev) begin check("R5 strobe width", rd_hi, RD_W); rd_hi = 0; end
      // Sample output.
      if (smp_valid) begin
        check("R6 valid single", int'(v_prev), 0);
        check("R6 sample value", int'(smp_data), int'(model_val));
        check("R6 valid latency", cyc - fall_cyc, 3 + RD_W);
        check("R7 hold between captures", int'(stray), 0);
        stray = 0; n_valid++;
      end else if (smp_data != prev_data) begin
        stray = 1;
      end
      prev_data = smp_data; cs_prev = conv_start; rd_prev = rd_strobe; v_prev = smp_valid;
    end
  end

  task automatic wait_rises(input int n);
    int target = n_rises + n;
    while (n_rises < target) @(posedge clk);
    #1;
  endtask

  task automatic check_reset_state();
    check("R9 conv_start in reset", int'(conv_start), 0);
    check("R9 rd_strobe in reset", int'(rd_strobe), 0);
    check("R9 smp_valid in reset", int'(smp_valid), 0);
    check("R9 overrun in reset", int'(overrun), 0);
    check("R9 smp_data in reset", int'(smp_data), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    check_reset_state();
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check("R3 first start after reset", int'(conv_start), 1);

    // Table walk over rates and conversion lengths.
    for (int i = 0; i < NVEC; i++) begin
      int nv0;
      int exp_p;
      rate_sel = VEC[i][15:14];
      conv_len = int'(VEC[i][13:0]);
      exp_p = BASE * (1 << (2 * int'(VEC[i][15:14])));
      nv0 = n_valid;
      wait_rises(3);
      check("R1 start spacing", last_interval, exp_p);
      check("R6 captures seen", int'(n_valid - nv0 >= 2), 1);
    end
    check("R8 no overrun when keeping pace", int'(overrun), 0);

    // Boundary reload: change from slow to fast just after a start.
    rate_sel = 2'd2; conv_len = 10;
    wait_rises(3);
    rate_sel = 2'd0;
    wait_rises(1);
    check("R4 running period keeps old length", last_interval, BASE * 16);
    wait_rises(1);
    check("R4 new length after boundary", last_interval, BASE);

    // Overrun: conversion longer than the period.
    conv_len = 60;
    wait_rises(2);
    check("R8 skipped start doubles spacing", last_interval, 2 * BASE);
    check("R8 overrun raised", int'(overrun), 1);
    conv_len = 10;
    wait_rises(3);
    check("R8 normal spacing resumes", last_interval, BASE);
    check("R8 overrun sticky", int'(overrun), 1);

    // Reset in mid-operation.
    @(negedge clk) rst_n = 0;
    @(negedge clk);
    check_reset_state();
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check("R3 first start after second reset", int'(conv_start), 1);
    wait_rises(3);
    check("R1 spacing after reset", last_interval, BASE);
    check("R8 overrun cleared by reset", int'(overrun), 0);

    finish_run();
  end

endmodule